// File: doc/BRIEF.md
# Five-Stage In-Order Integer Core

This block is a small 32-bit in-order processor. It overlaps each instruction across five steps: fetch, decode, execute, memory access and register writeback. It runs a reduced load/store instruction subset of word load, word store, add, subtract, bitwise AND and bitwise OR. The instruction store and the data store are arrays inside the core. A testbench fills them, and the register file, before it releases reset.

Control is decoded once, in the decode step. It is split into three bundles:

- an execute bundle: destination select, operand select and ALU operation;
- a memory bundle: read enable and write enable;
- a writeback bundle: register write and result select.

Each bundle travels in the inter-stage registers until the step that uses it, and is then dropped. The destination register number is carried to writeback.

The core does not detect hazards, forward results, stall or branch. Programs must therefore keep each reader of a register at least three instructions after the writer of that register. The observable outputs are the program counter and the register write port.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high on a clock edge, the PC becomes 0 and every pipeline control bit is cleared. After release, `dbg_wb_en` stays low until the first instruction reaches writeback.
- R2: After reset, the PC grows by exactly 4 on every clock edge. It has no enable.
- R3: A load has opcode bits [31:26] = 0x23, base register in [25:21], target in [20:16] and offset in [15:0]. It writes the data word at byte address base + sign-extended offset into the target register. Address bits [1:0] are ignored.
- R4: An R-type instruction has opcode 0, shamt [10:6] = 0 and a function code in [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. It writes the result of sources [25:21] and [20:16] into the register in [15:11].
- R5: A store (opcode 0x2B, fields laid out as for a load) writes the value of register [20:16] to the data word at base + sign-extended offset. It never raises `dbg_wb_en`.
- R6: Counting clock edges from the release of reset, the instruction at word k appears on the write port after edge k+4. One instruction retires per edge once the pipe is full.
- R7: Register 0 always reads as zero. A write aimed at it is discarded, and `dbg_wb_en` stays low.
- R8: A written register returns its new value to every later read. This includes a read made in decode during the same cycle as the write.
- R9: Any other opcode, R-type function code, or nonzero shamt travels as a bubble: it makes no register write and no store.
- R10: Start with each register preset to its index + 100 and every data word set to 99. The sequence lw $8,4($29); sub $2,$4,$5; and $9,$10,$11; or $16,$17,$18; add $13,$14,$0 then writes 99, -1, 110, 119 and 114. The last write is reported in the ninth cycle after release.
- R11: The 16-bit offset is sign-extended, so a negative offset addresses below the base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Current fetch address |
| dbg_wb_en | output | 1 | Register write taking effect this cycle |
| dbg_wb_addr | output | 5 | Register being written |
| dbg_wb_data | output | 32 | Value being written |

## Verification
The checks inside the core take for granted that every program is free of hazards: no instruction reads a register written by either of the two instructions just before it. They also take for granted that every load and store address falls inside the data array. The reference model in the bench runs instructions strictly in program order, so it only predicts the core correctly under these same conditions. The stimulus programs are therefore written by hand to keep each dependent pair at least three slots apart, and to use small bases and offsets. Reset is held over at least two edges before each program, so that the fetch register and all control bundles start cleared.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int OPW  = 6;

  localparam logic [OPW-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPW-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPW-1:0] OPC_STORE = 6'h2B;
  localparam logic [5:0]     FN_ADD    = 6'h20;
  localparam logic [5:0]     FN_SUB    = 6'h22;
  localparam logic [5:0]     FN_AND    = 6'h24;
  localparam logic [5:0]     FN_OR     = 6'h25;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  // execute bundle
  typedef struct packed {
    logic    dst_rd;
    logic    src_imm;
    alu_op_e op;
  } ex_ctl_t;

  // memory bundle
  typedef struct packed {
    logic rd_en;
    logic wr_en;
  } mem_ctl_t;

  // writeback bundle
  typedef struct packed {
    logic reg_we;
    logic from_mem;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t         ex;
    mem_ctl_t        m;
    wb_ctl_t         wb;
    logic [XLEN-1:0] a_val;
    logic [XLEN-1:0] b_val;
    logic [XLEN-1:0] imm;
    logic [RIDX-1:0] rt;
    logic [RIDX-1:0] rd;
  } idex_t;

  typedef struct packed {
    mem_ctl_t        m;
    wb_ctl_t         wb;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] st_data;
    logic [RIDX-1:0] dest;
  } exmem_t;

  typedef struct packed {
    wb_ctl_t         wb;
    logic [XLEN-1:0] alu;
    logic [RIDX-1:0] dest;
  } memwb_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [OPW-1:0] opc,
  input  logic [4:0]     shamt,
  input  logic [5:0]     funct,
  output ex_ctl_t        ex,
  output mem_ctl_t       mem,
  output wb_ctl_t        wb
);
  always_comb begin
    ex  = '0;
    mem = '0;
    wb  = '0;
    case (opc)
      OPC_LOAD: begin
        ex.src_imm  = 1'b1;
        ex.op       = ALU_ADD;
        mem.rd_en   = 1'b1;
        wb.reg_we   = 1'b1;
        wb.from_mem = 1'b1;
      end
      OPC_STORE: begin
        ex.src_imm = 1'b1;
        ex.op      = ALU_ADD;
        mem.wr_en  = 1'b1;
      end
      OPC_RTYPE: begin
        if (shamt == '0) begin
          ex.dst_rd = 1'b1;
          wb.reg_we = 1'b1;
          case (funct)
            FN_ADD:  ex.op = ALU_ADD;
            FN_SUB:  ex.op = ALU_SUB;
            FN_AND:  ex.op = ALU_AND;
            FN_OR:   ex.op = ALU_OR;
            default: begin
              ex.dst_rd = 1'b0;
              wb.reg_we = 1'b0;
            end
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter  int NREG   = 32,
  parameter  int W      = 32,
  parameter  int NREAD  = 2,
  localparam int AW     = $clog2(NREG)
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra [NREAD],
  output logic [W-1:0]  rd [NREAD]
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  // write lands before the read in the same cycle
  for (genvar p = 0; p < NREAD; p++) begin : g_rport
    always_comb begin
      if (ra[p] == '0)               rd[p] = '0;
      else if (we && wa == ra[p])    rd[p] = wd;
      else                           rd[p] = regs[ra[p]];
    end
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256
)(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] dbg_pc,
  output logic            dbg_wb_en,
  output logic [RIDX-1:0] dbg_wb_addr,
  output logic [XLEN-1:0] dbg_wb_data
);
  localparam int IAW     = $clog2(IMEM_WORDS);
  localparam int DAW     = $clog2(DMEM_WORDS);
  localparam int NREG    = 1 << RIDX;
  localparam int PC_STEP = 4;

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) dmem[i] = '0;
  end

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] ifid_instr;
  idex_t           idex;
  exmem_t          exmem;
  memwb_t          memwb;
  logic [XLEN-1:0] mwb_mdata;

  // ---------------- fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      ifid_instr <= '0;
    end else begin
      pc         <= pc + XLEN'(PC_STEP);
      ifid_instr <= imem[pc[IAW+1:2]];
    end
  end

  // ---------------- decode
  ex_ctl_t         dec_ex;
  mem_ctl_t        dec_m;
  wb_ctl_t         dec_wb;
  logic [RIDX-1:0] rf_ra [2];
  logic [XLEN-1:0] rf_rd [2];
  logic            wb_we;
  logic [XLEN-1:0] wb_data;

  pipe5_decode u_dec (
    .opc   (ifid_instr[31:26]),
    .shamt (ifid_instr[10:6]),
    .funct (ifid_instr[5:0]),
    .ex    (dec_ex),
    .mem   (dec_m),
    .wb    (dec_wb)
  );

  assign rf_ra[0] = ifid_instr[25:21];
  assign rf_ra[1] = ifid_instr[20:16];

  pipe5_regfile #(.NREG(NREG), .W(XLEN), .NREAD(2)) u_rf (
    .clk (clk),
    .we  (wb_we),
    .wa  (memwb.dest),
    .wd  (wb_data),
    .ra  (rf_ra),
    .rd  (rf_rd)
  );

  always_ff @(posedge clk) begin
    idex.a_val <= rf_rd[0];
    idex.b_val <= rf_rd[1];
    idex.imm   <= {{(XLEN-16){ifid_instr[15]}}, ifid_instr[15:0]};
    idex.rt    <= ifid_instr[20:16];
    idex.rd    <= ifid_instr[15:11];
    if (rst) begin
      idex.ex <= '0;
      idex.m  <= '0;
      idex.wb <= '0;
    end else begin
      idex.ex <= dec_ex;
      idex.m  <= dec_m;
      idex.wb <= dec_wb;
    end
  end

  // ---------------- execute (execute bundle consumed here)
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;

  assign alu_b = idex.ex.src_imm ? idex.imm : idex.b_val;

  pipe5_alu u_alu (
    .a  (idex.a_val),
    .b  (alu_b),
    .op (idex.ex.op),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    exmem.alu     <= alu_y;
    exmem.st_data <= idex.b_val;
    exmem.dest    <= idex.ex.dst_rd ? idex.rd : idex.rt;
    if (rst) begin
      exmem.m  <= '0;
      exmem.wb <= '0;
    end else begin
      exmem.m  <= idex.m;
      exmem.wb <= idex.wb;
    end
  end

  // ---------------- memory (memory bundle consumed here)
  logic [DAW-1:0] dm_idx;
  assign dm_idx = exmem.alu[DAW+1:2];

  always_ff @(posedge clk) begin
    if (!rst && exmem.m.wr_en) dmem[dm_idx] <= exmem.st_data;
    mwb_mdata <= dmem[dm_idx];
  end

  always_ff @(posedge clk) begin
    memwb.alu  <= exmem.alu;
    memwb.dest <= exmem.dest;
    if (rst) memwb.wb <= '0;
    else     memwb.wb <= exmem.wb;
  end

  // ---------------- writeback
  assign wb_data = memwb.wb.from_mem ? mwb_mdata : memwb.alu;
  assign wb_we   = memwb.wb.reg_we && (memwb.dest != '0);

  assign dbg_pc      = pc;
  assign dbg_wb_en   = wb_we;
  assign dbg_wb_addr = memwb.dest;
  assign dbg_wb_data = wb_data;

  // ---------------- checks
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc == $past(pc) + XLEN'(PC_STEP)));

  // R1
  reset_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dbg_wb_en);

  // R5
  store_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    exmem.m.wr_en |=> !dbg_wb_en);

  // R9
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exmem.m.rd_en, exmem.m.wr_en}));

  // R8
  rf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wb_we) && rf_ra[0] == $past(memwb.dest) &&
     !(wb_we && memwb.dest == rf_ra[0])) |-> (rf_rd[0] == $past(wb_data)));

  // R3 (programs keep data addresses inside the array)
  dmem_range_chk: assert property (@(posedge clk) disable iff (rst)
    (exmem.m.rd_en || exmem.m.wr_en) |-> ((exmem.alu >> (DAW + 2)) == '0));
endmodule

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IMEM_WORDS = 256;
  localparam int DMEM_WORDS = 256;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wb_en;
  logic [4:0]  dbg_wb_addr;
  logic [31:0] dbg_wb_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  pipe5_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_pipe5_core (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wb_en(dbg_wb_en),
    .dbg_wb_addr(dbg_wb_addr), .dbg_wb_data(dbg_wb_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R6: actual %0d cycles expected under %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  // ------------------------------------------------ encoders
  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn, int sh = 0);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  // ------------------------------------------------ reference model
  typedef struct {
    bit          en;
    logic [4:0]  a;
    logic [31:0] d;
    string       tag;
  } wb_exp_t;

  logic [31:0] prog [$];
  wb_exp_t     expq [$];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DMEM_WORDS];

  function automatic logic [31:0] rget(int r);
    return (r == 0) ? 32'd0 : m_reg[r];
  endfunction

  task automatic model_run(string base_tag);
    expq.delete();
    foreach (prog[k]) begin
      logic [31:0] w;
      int op, rs, rt, rd, sh, fn, idx;
      logic [31:0] ea, res;
      wb_exp_t e;
      w  = prog[k];
      op = int'(w[31:26]); rs = int'(w[25:21]); rt = int'(w[20:16]);
      rd = int'(w[15:11]); sh = int'(w[10:6]);  fn = int'(w[5:0]);
      ea = rget(rs) + {{16{w[15]}}, w[15:0]};
      idx = int'(ea >> 2) % DMEM_WORDS;
      e.en = 1'b0; e.a = '0; e.d = '0; e.tag = "R9";
      if (op == 'h23) begin
        e.tag = (rt == 0) ? "R7" : base_tag.len() ? base_tag : "R3";
        if (rt != 0) begin
          e.en = 1'b1; e.a = rt[4:0]; e.d = m_mem[idx]; m_reg[rt] = m_mem[idx];
        end
      end else if (op == 'h2B) begin
        e.tag = "R5";
        m_mem[idx] = rget(rt);
      end else if (op == 0 && sh == 0 &&
                   (fn == 'h20 || fn == 'h22 || fn == 'h24 || fn == 'h25)) begin
        case (fn)
          'h20:    res = rget(rs) + rget(rt);
          'h22:    res = rget(rs) - rget(rt);
          'h24:    res = rget(rs) & rget(rt);
          default: res = rget(rs) | rget(rt);
        endcase
        e.tag = (rd == 0) ? "R7" : base_tag.len() ? base_tag : "R4";
        if (rd != 0) begin
          e.en = 1'b1; e.a = rd[4:0]; e.d = res; m_reg[rd] = res;
        end
      end
      expq.push_back(e);
    end
  endtask

  // ------------------------------------------------ run one program
  task automatic run_prog(bit ramp, string base_tag);
    rst = 1'b1;
    for (int i = 0; i < 32; i++) begin
      u_pipe5_core.u_rf.regs[i] = 32'(i + 100);
      m_reg[i] = 32'(i + 100);
    end
    for (int i = 0; i < DMEM_WORDS; i++) begin
      u_pipe5_core.dmem[i] = ramp ? 32'(1000 + i) : 32'd99;
      m_mem[i] = ramp ? 32'(1000 + i) : 32'd99;
    end
    for (int i = 0; i < IMEM_WORDS; i++)
      u_pipe5_core.imem[i] = (i < prog.size()) ? prog[i] : 32'd0;
    model_run(base_tag);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dbg_pc == 0, "R1", "pc in reset", dbg_pc, 0);
    chk(!dbg_wb_en, "R1", "write enable in reset", 32'(dbg_wb_en), 0);
    rst = 1'b0;
    for (int n = 0; n < prog.size() + 6; n++) begin
      int j;
      chk(dbg_pc == 32'(4 * n), "R2", "pc", dbg_pc, 32'(4 * n));
      j = n - 4;
      if (j < 0) begin
        chk(!dbg_wb_en, "R1", "bubble after reset", 32'(dbg_wb_en), 0);
      end else if (j >= prog.size()) begin
        chk(!dbg_wb_en, "R6", "drained pipe", 32'(dbg_wb_en), 0);
      end else begin
        wb_exp_t e;
        e = expq[j];
        chk(dbg_wb_en == e.en, e.tag, "write enable", 32'(dbg_wb_en), 32'(e.en));
        if (e.en) begin
          chk(dbg_wb_addr == e.a, e.tag, "write register", 32'(dbg_wb_addr), 32'(e.a));
          chk(dbg_wb_data == e.d, e.tag, "write value", dbg_wb_data, e.d);
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    // R10: the five-instruction example; last write after edge 8 (ninth cycle)
    prog.delete();
    prog.push_back(enc_i('h23, 29, 8, 4));
    prog.push_back(enc_r(4, 5, 2, 'h22));
    prog.push_back(enc_r(10, 11, 9, 'h24));
    prog.push_back(enc_r(17, 18, 16, 'h25));
    prog.push_back(enc_r(14, 0, 13, 'h20));
    run_prog(1'b0, "R10");
    chk(m_reg[8] == 99 && m_reg[2] == 32'hFFFF_FFFF && m_reg[9] == 110 &&
        m_reg[16] == 119 && m_reg[13] == 114, "R10", "model results",
        m_reg[13], 114);

    // stores, register 0, bypass, negative offset, bubbles
    prog.delete();
    prog.push_back(enc_i('h2B, 0, 5, 8));        // R5 store 105 to word 2
    prog.push_back(enc_r(6, 7, 0, 'h20));        // R7 write to reg 0
    prog.push_back(enc_i('h23, 0, 20, 8));       // R3 reload word 2
    prog.push_back(enc_r(0, 0, 21, 'h25));       // R7 reg 0 reads zero
    prog.push_back(enc_r(3, 9, 22, 'h22));       // R4 sub, negative
    prog.push_back(enc_r(20, 20, 23, 'h20));     // R8 same-cycle read of $20
    prog.push_back(enc_i('h23, 12, 24, -12));    // R11 negative offset
    prog.push_back(enc_i('h08, 1, 25, 3));       // R9 unknown opcode
    prog.push_back(enc_r(1, 2, 25, 'h21));       // R9 unknown function
    prog.push_back(enc_r(1, 2, 26, 'h20, 1));    // R9 nonzero shamt
    prog.push_back(enc_r(22, 23, 27, 'h24));     // R4 and
    prog.push_back(enc_i('h2B, 0, 23, 12));      // R5 store computed value
    prog.push_back(enc_i('h23, 0, 28, 12));      // R5 read it back
    run_prog(1'b1, "");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule